// File: doc/BRIEF.md
# Serial Line Rate Learner with Handshake

This block watches a UART receive line while the device sits in a boot or setup state and works out the host's bit rate on its own. After a start strobe it waits for the line to rest high for a while. It then times the first low run that follows. The host sends the byte 0x00 over and over, with 8 data bits, 1 stop bit, no parity and LSB first. One such frame shows up as a single low stretch made of the start bit and the eight zero data bits, which is nine bit times long. After the low stretch the line stays high for at least the stop bit. The clocks-per-bit divisor is that low length divided by nine, rounded to the nearest integer.

Once it has the divisor, the block answers with one 0x00 frame on its transmit line at the learned rate. This tells the host that the adjustment is over. It then listens for a single confirmation byte, 0x55, at the same rate. A correct confirmation ends the sequence in the done state. Any of the following ends it in the error state: a wrong byte, a low stop bit, a silent host, or a low run that cannot be timed. Both end states hold until reset, and a reset is the only way to try again. The block is meant for host rates of 2400, 4800 and 9600 bps, a 1:2:4 set; other rates may give a divisor too coarse for later traffic.

The divisor is a held result qualified by a valid flag. It is not a stream. It never changes once valid, so a consumer needs no ready and there is no back-pressure to honour. The serial lines carry their own framing, and the status pins are plain levels.

Top module: `autobaud_sync`

## Requirements
- R1: In reset and right after it, tx_o is high and done_o, err_o and div_valid_o are low.
- R2: Timing begins only after a start strobe. The timed low run is the first one whose falling edge comes after at least IDLE_CLKS consecutive high clocks seen since the strobe. Earlier low runs are skipped.
- R3: When the timed low run of L clocks ends, div_o becomes round(L/9) (that is, (L+4)/9 truncated), div_valid_o goes high, and both then hold steady until reset.
- R4: A low run that reaches 2^CNT_W-1 clocks, or one that gives a divisor below 2, sets err_o.
- R5: After the divisor is set, tx_o sends one frame: a low start bit, eight data bits of 0 sent LSB first, and a high stop bit, each div_o clocks long. At all other times tx_o is high.
- R6: After the echo frame, a received byte of 0x55 (LSB first, sampled mid-bit at div_o clocks per bit) with a high stop bit sets done_o.
- R7: A received confirmation byte other than 0x55 sets err_o, and done_o stays low.
- R8: A confirmation frame whose stop bit reads low sets err_o, even if its data is 0x55.
- R9: If no start edge arrives within TMO_BITS bit times (TMO_BITS*div_o clocks) after the echo stop bit ends, err_o is set. A start edge that arrives before the deadline stops the count.
- R10: done_o and err_o are sticky and never both high. While either is high, further start strobes and line activity leave done_o, err_o, div_o and tx_o unchanged.
- R11: Line activity before a start strobe does not set div_valid_o and causes no transmission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-clock strobe that arms rate learning |
| rx_i | input | 1 | Serial receive line from the host (idle high) |
| tx_o | output | 1 | Serial transmit line to the host (idle high) |
| div_o | output | CNT_W | Learned clocks-per-bit divisor |
| div_valid_o | output | 1 | div_o holds a learned value |
| done_o | output | 1 | Confirmation byte accepted |
| err_o | output | 1 | Sequence failed; reset needed |

## Verification
Two things can resolve in the same cycle while the block waits for the confirmation: the bit-time timeout can expire, and the receiver can detect the start edge of the confirmation frame. The design settles this by freezing the timeout count while the receiver is busy. A completed frame is looked at before the count. The bench provokes the race from both sides. It holds the confirmation back until well inside the window and expects done. It holds the line idle until just past the window and expects err, with the deadline worked out from the echo's stop bit and the learned divisor.

// File: rtl/abd_pkg.sv
package abd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MEAS,
    ST_ECHO,
    ST_ECHO_WAIT,
    ST_CONF,
    ST_DONE,
    ST_FAIL
  } abd_state_e;

  localparam logic [7:0] ECHO_BYTE    = 8'h00;
  localparam logic [7:0] CONFIRM_BYTE = 8'h55;
endpackage

// File: rtl/abd_meter.sv
module abd_meter #(
  parameter int CNT_W     = 12,
  parameter int IDLE_CLKS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             rx,
  output logic             done,
  output logic             sat,
  output logic [CNT_W-1:0] low_cnt
);
  localparam int IDLE_W = $clog2(IDLE_CLKS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [IDLE_W-1:0] IDLE_LAST = IDLE_W'(IDLE_CLKS - 1);

  logic [IDLE_W-1:0] idle_cnt;
  logic              idle_ok;
  logic              counting;
  logic [CNT_W-1:0]  cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idle_cnt <= '0;
      idle_ok  <= 1'b0;
      counting <= 1'b0;
      cnt      <= '0;
      done     <= 1'b0;
      sat      <= 1'b0;
    end else begin
      done <= 1'b0;
      sat  <= 1'b0;
      if (!arm) begin
        idle_cnt <= '0;
        idle_ok  <= 1'b0;
        counting <= 1'b0;
        cnt      <= '0;
      end else if (!counting) begin
        if (rx) begin
          if (idle_cnt == IDLE_LAST) idle_ok <= 1'b1;
          else idle_cnt <= idle_cnt + 1'b1;
        end else if (idle_ok) begin
          counting <= 1'b1;
          cnt      <= CNT_W'(1);
        end else begin
          idle_cnt <= '0;
        end
      end else if (!rx) begin
        if (cnt == CNT_MAX) begin
          sat      <= 1'b1;
          counting <= 1'b0;
          idle_ok  <= 1'b0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        done     <= 1'b1;
        counting <= 1'b0;
        idle_ok  <= 1'b0;
      end
    end
  end

  assign low_cnt = cnt;

  // R4: saturation is only reported once the count has hit its ceiling
  p_sat_at_max_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sat |-> $past(cnt) == CNT_MAX);
  // R2: a finished run is always preceded by an active count
  p_done_after_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(counting));
endmodule

// File: rtl/abd_tx.sv
module abd_tx #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [7:0]       byte_i,
  input  logic [DIV_W-1:0] div,
  output logic             tx_o,
  output logic             busy
);
  logic [8:0]       shreg;
  logic [3:0]       idx;
  logic [DIV_W-1:0] cnt;
  logic             line;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg <= '1;
      idx   <= '0;
      cnt   <= '0;
      line  <= 1'b1;
      busy  <= 1'b0;
    end else if (!busy) begin
      if (go) begin
        shreg <= {1'b1, byte_i};
        idx   <= '0;
        cnt   <= div - DIV_W'(1);
        line  <= 1'b0;
        busy  <= 1'b1;
      end
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end else if (idx == 4'd9) begin
      busy <= 1'b0;
      line <= 1'b1;
    end else begin
      line  <= shreg[0];
      shreg <= {1'b1, shreg[8:1]};
      idx   <= idx + 1'b1;
      cnt   <= div - DIV_W'(1);
    end
  end

  assign tx_o = line;

  // R5: an idle transmitter leaves the line high
  p_tx_idle_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> tx_o);
  // R5: a frame always opens with a low start bit
  p_tx_start_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !tx_o);
endmodule

// File: rtl/abd_rx.sv
module abd_rx #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             rx,
  input  logic [DIV_W-1:0] div,
  output logic [7:0]       byte_o,
  output logic             valid_o,
  output logic             ferr_o,
  output logic             busy_o
);
  logic             prev;
  logic [DIV_W-1:0] cnt;
  logic [3:0]       idx;
  logic [7:0]       shreg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev    <= 1'b1;
      cnt     <= '0;
      idx     <= '0;
      shreg   <= '0;
      busy_o  <= 1'b0;
      valid_o <= 1'b0;
      ferr_o  <= 1'b0;
    end else begin
      prev    <= rx;
      valid_o <= 1'b0;
      ferr_o  <= 1'b0;
      if (!busy_o) begin
        if (en && prev && !rx) begin
          busy_o <= 1'b1;
          cnt    <= div >> 1;
          idx    <= '0;
        end
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end else begin
        cnt <= div - DIV_W'(1);
        if (idx == 4'd0) begin
          if (rx) busy_o <= 1'b0;
          else idx <= 4'd1;
        end else if (idx <= 4'd8) begin
          shreg <= {rx, shreg[7:1]};
          idx   <= idx + 1'b1;
        end else begin
          busy_o  <= 1'b0;
          valid_o <= 1'b1;
          ferr_o  <= !rx;
        end
      end
    end
  end

  assign byte_o = shreg;

  // R6: a finished frame is only reported out of an active reception
  p_rx_valid_from_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(busy_o));
  // R8: a framing error never appears without a finished frame
  p_rx_ferr_in_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ferr_o |-> !busy_o);
endmodule

// File: rtl/autobaud_sync.sv
module autobaud_sync
  import abd_pkg::*;
#(
  parameter int CNT_W     = 12,
  parameter int IDLE_CLKS = 32,
  parameter int TMO_BITS  = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             rx_i,
  output logic             tx_o,
  output logic [CNT_W-1:0] div_o,
  output logic             div_valid_o,
  output logic             done_o,
  output logic             err_o
);
  localparam int DIV_W = CNT_W;
  localparam int TMO_W = $clog2(TMO_BITS + 1);
  localparam logic [CNT_W:0] NINE = (CNT_W + 1)'(9);
  localparam logic [CNT_W:0] HALF_NINE = (CNT_W + 1)'(4);
  localparam logic [DIV_W-1:0] DIV_MIN = DIV_W'(2);
  localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(TMO_BITS - 1);

  abd_state_e state;
  logic rx_meta, rx_s;
  logic m_done, m_sat;
  logic [CNT_W-1:0] m_cnt;
  logic [CNT_W:0]   rounded;
  logic [CNT_W:0]   quot;
  logic [DIV_W-1:0] div_calc;
  logic [DIV_W-1:0] div_q;
  logic             div_vq;
  logic             tx_busy;
  logic [7:0]       rx_byte;
  logic             rx_valid, rx_ferr, rx_busy;
  logic [DIV_W-1:0] tmo_clk;
  logic [TMO_W-1:0] tmo_bits;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_meta <= 1'b1;
      rx_s    <= 1'b1;
    end else begin
      rx_meta <= rx_i;
      rx_s    <= rx_meta;
    end
  end

  abd_meter #(.CNT_W(CNT_W), .IDLE_CLKS(IDLE_CLKS)) u_meter (
    .clk(clk), .rst_n(rst_n), .arm(state == ST_MEAS), .rx(rx_s),
    .done(m_done), .sat(m_sat), .low_cnt(m_cnt)
  );

  assign rounded  = {1'b0, m_cnt} + HALF_NINE;
  assign quot     = rounded / NINE;
  assign div_calc = quot[DIV_W-1:0];

  abd_tx #(.DIV_W(DIV_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .go(state == ST_ECHO), .byte_i(ECHO_BYTE),
    .div(div_q), .tx_o(tx_o), .busy(tx_busy)
  );

  abd_rx #(.DIV_W(DIV_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .en(state == ST_CONF), .rx(rx_s), .div(div_q),
    .byte_o(rx_byte), .valid_o(rx_valid), .ferr_o(rx_ferr), .busy_o(rx_busy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      div_q    <= '0;
      div_vq   <= 1'b0;
      tmo_clk  <= '0;
      tmo_bits <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start_i) state <= ST_MEAS;
        ST_MEAS: begin
          if (m_sat) state <= ST_FAIL;
          else if (m_done) begin
            if (div_calc < DIV_MIN) state <= ST_FAIL;
            else begin
              div_q  <= div_calc;
              div_vq <= 1'b1;
              state  <= ST_ECHO;
            end
          end
        end
        ST_ECHO: state <= ST_ECHO_WAIT;
        ST_ECHO_WAIT: if (!tx_busy) begin
          state    <= ST_CONF;
          tmo_clk  <= '0;
          tmo_bits <= '0;
        end
        ST_CONF: begin
          if (rx_valid) begin
            state <= (!rx_ferr && rx_byte == CONFIRM_BYTE) ? ST_DONE : ST_FAIL;
          end else if (!rx_busy) begin
            if (tmo_clk == div_q - DIV_W'(1)) begin
              tmo_clk <= '0;
              if (tmo_bits == TMO_LAST) state <= ST_FAIL;
              else tmo_bits <= tmo_bits + 1'b1;
            end else begin
              tmo_clk <= tmo_clk + 1'b1;
            end
          end
        end
        ST_DONE: state <= ST_DONE;
        ST_FAIL: state <= ST_FAIL;
        default: state <= ST_FAIL;
      endcase
    end
  end

  assign div_o       = div_q;
  assign div_valid_o = div_vq;
  assign done_o      = (state == ST_DONE);
  assign err_o       = (state == ST_FAIL);

  // R10: end states are sticky
  p_done_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> done_o);
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);
  // R3: a learned divisor never moves
  p_div_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (div_valid_o && $past(div_valid_o)) |-> $stable(div_o));
  // R5: the line is only driven low while the echo frame is pending
  p_tx_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_ECHO_WAIT) |-> tx_o);
  // R6: done is entered only on a completed reception
  p_done_from_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(rx_valid));
endmodule

// File: tb/sim_autobaud_sync.sv
module sim_autobaud_sync;
  localparam int CNT_W = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic rx = 1'b1;
  logic tx;
  logic [CNT_W-1:0] div;
  logic div_valid, done, err;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  autobaud_sync #(.CNT_W(CNT_W), .IDLE_CLKS(32), .TMO_BITS(12)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .rx_i(rx), .tx_o(tx),
    .div_o(div), .div_valid_o(div_valid), .done_o(done), .err_o(err)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run hung (actual %0d cycles, expected fewer)", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int n);
    rx = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    rx = 1'b1;
    start = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic send_byte(input int b, input logic [7:0] d, input logic stopv);
    hold(1'b0, b);
    for (int i = 0; i < 8; i++) hold(d[i], b);
    hold(stopv, b);
    rx = 1'b1;
  endtask

  // Catch the echo frame on tx and check it bit by bit (R5)
  task automatic get_echo(input int b);
    int waited = 0;
    logic [7:0] got = '1;
    while (tx && waited < 400) begin
      @(negedge clk);
      waited++;
    end
    chk(!tx, "R5 echo start seen", int'(tx), 0);
    repeat (b / 2) @(negedge clk);
    chk(!tx, "R5 echo start bit low", int'(tx), 0);
    for (int i = 0; i < 8; i++) begin
      repeat (b) @(negedge clk);
      got[i] = tx;
    end
    chk(got == 8'h00, "R5 echo data", int'(got), 0);
    repeat (b) @(negedge clk);
    chk(tx === 1'b1, "R5 echo stop bit high", int'(tx), 1);
  endtask

  task automatic bring_up(input int b);
    do_reset();
    pulse_start();
    hold(1'b1, 40);
    hold(1'b0, 9 * b);
    rx = 1'b1;
    get_echo(b);
    chk(div_valid && (int'(div) >= b - 1) && (int'(div) <= b + 1),
        "R3 divisor within one of bit time", int'(div), b);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(tx && !done && !err && !div_valid, "R1 reset outputs",
        {tx, done, err, div_valid}, 4'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx && !done && !err && !div_valid, "R1 after release",
        {tx, done, err, div_valid}, 4'b1000);
  endtask

  task automatic t_prestart();
    do_reset();
    hold(1'b1, 40);
    hold(1'b0, 9 * 32);
    hold(1'b1, 200);
    chk(!div_valid, "R11 no divisor without start", int'(div_valid), 0);
    chk(tx, "R11 no transmission without start", int'(tx), 1);
  endtask

  task automatic t_rate(input int b);
    bring_up(b);
    hold(1'b1, 2 * b);
    send_byte(b, 8'h55, 1'b1);
    hold(1'b1, 4);
    chk(done && !err, "R6 confirmation accepted", {done, err}, 2'b10);
  endtask

  task automatic t_skip_early();
    do_reset();
    pulse_start();
    hold(1'b1, 5);
    hold(1'b0, 9 * 40);
    hold(1'b1, 100);
    hold(1'b0, 9 * 32);
    rx = 1'b1;
    get_echo(32);
    chk(int'(div) == 32, "R2 early low run skipped", int'(div), 32);
  endtask

  task automatic t_round(input int low, input int exp);
    do_reset();
    pulse_start();
    hold(1'b1, 40);
    hold(1'b0, low);
    hold(1'b1, 6);
    chk(div_valid && int'(div) == exp, "R3 rounding of divide by nine", int'(div), exp);
  endtask

  task automatic t_wrong();
    bring_up(32);
    hold(1'b1, 2 * 32);
    send_byte(32, 8'hAA, 1'b1);
    hold(1'b1, 4);
    chk(err && !done, "R7 wrong byte rejected", {done, err}, 2'b01);
  endtask

  task automatic t_framing();
    bring_up(16);
    hold(1'b1, 2 * 16);
    send_byte(16, 8'h55, 1'b0);
    hold(1'b1, 4);
    chk(err && !done, "R8 low stop bit rejected", {done, err}, 2'b01);
  endtask

  task automatic t_timeout();
    bring_up(32);
    hold(1'b1, 8 * 32);
    chk(!err, "R9 no error inside window", int'(err), 0);
    send_byte(32, 8'h55, 1'b1);
    hold(1'b1, 4);
    chk(done && !err, "R9 late but in-window confirmation", {done, err}, 2'b10);
    bring_up(32);
    hold(1'b1, 14 * 32);
    chk(err && !done, "R9 timeout past window", {done, err}, 2'b01);
  endtask

  task automatic t_sat();
    do_reset();
    pulse_start();
    hold(1'b1, 40);
    hold(1'b0, 4200);
    rx = 1'b1;
    @(negedge clk);
    chk(err && !div_valid, "R4 saturated low run", {err, div_valid}, 2'b10);
    do_reset();
    pulse_start();
    hold(1'b1, 40);
    hold(1'b0, 9);
    hold(1'b1, 6);
    chk(err && !div_valid, "R4 divisor below two", {err, div_valid}, 2'b10);
  endtask

  task automatic t_sticky();
    logic [CNT_W-1:0] d0;
    t_rate(16);
    d0 = div;
    pulse_start();
    hold(1'b1, 40);
    hold(1'b0, 9 * 16);
    hold(1'b1, 300);
    chk(done && !err && div == d0 && tx, "R10 start ignored after done",
        {done, err, tx}, 3'b101);
  endtask

  initial begin
    t_reset();
    t_prestart();
    t_rate(64);
    t_rate(32);
    t_rate(16);
    t_skip_early();
    t_round(9 * 20 + 4, 20);
    t_round(9 * 20 + 5, 21);
    t_wrong();
    t_framing();
    t_timeout();
    t_sat();
    t_sticky();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule